// File: doc/BRIEF.md
# Exception Entry Sequencer

This block moves a processor core from ordinary execution into an exception handler in a single step. Each clock it looks at the current status word, the program counter, the vector of enabled pending interrupt sources, a master interrupt enable, a flag showing that the prefetch buffer holds two instructions, and a software-trap request. When an entry is allowed, the block registers the full entry frame for the core to commit on the next cycle. The frame holds the updated status word, the status word to bank, the link value, the handler address, and strobes that start a prefetch reload, wake a halted core and ask for a register-bank switch.

The status word keeps its operating mode in bits [4:0], its interrupt-mask bit at bit 7 and its compact-instruction-state bit at bit 5. The sequencer writes those fields and leaves every other bit as it found it. The core keeps the banked storage itself. The block only presents the values to write and a strobe when the mode field changes.

Top module: `exc_entry_seq`

## Requirements
- R1: During reset and in the first cycle after it, stat_out is 0x1F, saved_stat, link_out and pc_out are zero, and reload, halt_rel and bank_sw are low.
- R2: An interrupt entry is taken at a clock edge when master_en is 1, stat_in bit 7 is 0, pend_in is nonzero and pf_full is 1. In the next cycle reload is high and pc_out is 0x18.
- R3: A trap entry is taken at a clock edge when trap_req and pf_full are both 1, whatever master_en, stat_in bit 7 and pend_in are. Its pc_out is 0x08. When an interrupt entry and a trap entry are both possible at the same edge, the interrupt entry is taken.
- R4: While pf_full is 0, no entry is taken. A request that is still held when pf_full rises is taken at that edge.
- R5: link_out is pc_in minus 4 when stat_in bit 5 is 0, and pc_in unchanged when stat_in bit 5 is 1. Both values are sampled at the entry edge.
- R6: saved_stat equals stat_in as sampled at the entry edge.
- R7: stat_out after an entry has bits [4:0] equal to 0x12 for an interrupt and 0x13 for a trap. Bit 7 is set, bit 5 is cleared, and all other bits are copied from stat_in.
- R8: reload is a one-cycle pulse for each entry, and pc_out holds the vector of that entry.
- R9: halt_rel pulses together with reload for an interrupt entry and stays low for a trap entry.
- R10: bank_sw pulses together with reload exactly when the new mode field differs from stat_in bits [4:0].
- R11: In a cycle with no entry, reload, halt_rel and bank_sw are low, and stat_out, saved_stat, link_out and pc_out keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_en | input | 1 | Global interrupt enable |
| stat_in | input | ST_W | Current status word |
| pc_in | input | ADDR_W | Current program counter |
| pend_in | input | PEND_W | Enabled pending interrupt sources |
| pf_full | input | 1 | Prefetch buffer holds two entries |
| trap_req | input | 1 | Software trap request |
| stat_out | output | ST_W | Status word to commit |
| saved_stat | output | ST_W | Status word to bank for the handler mode |
| link_out | output | ADDR_W | Return address for the link register |
| pc_out | output | ADDR_W | Handler vector address |
| reload | output | 1 | Prefetch reload strobe |
| halt_rel | output | 1 | Release a halted core |
| bank_sw | output | 1 | Mode field changed; switch register bank |

## Verification
The bench builds the block with a 6-bit pending vector instead of the default 14 bits. This makes an all-zero pending vector common under random stimulus, so the nonzero-pending gate gets tested both ways many times. Status words come from a pseudo-random generator that often starts in mode 0x12 or 0x13, so cycles with no bank switch occur alongside cycles with a switch. Traps are enabled, so the contention between a trap and an interrupt at the same edge is within reach.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

   typedef enum logic [1:0] {
      ENT_NONE = 2'd0,
      ENT_IRQ  = 2'd1,
      ENT_TRAP = 2'd2
   } ent_kind_t;

endpackage

// File: rtl/exc_gate.sv
module exc_gate
   import exc_seq_pkg::*;
#(
   parameter int ST_W    = 32,
   parameter int PEND_W  = 14,
   parameter int I_POS   = 7,
   parameter bit TRAP_EN = 1'b1
) (
   input  logic              master_en,
   input  logic [ST_W-1:0]   stat,
   input  logic [PEND_W-1:0] pend,
   input  logic              pf_full,
   input  logic              trap_req,
   output ent_kind_t         kind
);

   logic irq_ok;
   logic trap_ok;

   assign irq_ok = master_en & ~stat[I_POS] & (|pend) & pf_full;

   generate
      if (TRAP_EN) begin : g_trap
         assign trap_ok = trap_req & pf_full;
      end else begin : g_no_trap
         assign trap_ok = 1'b0 & trap_req;
      end
   endgenerate

   always_comb begin
      if (irq_ok)       kind = ENT_IRQ;
      else if (trap_ok) kind = ENT_TRAP;
      else              kind = ENT_NONE;
   end

endmodule

// File: rtl/exc_frame.sv
module exc_frame
   import exc_seq_pkg::*;
#(
   parameter int ST_W      = 32,
   parameter int ADDR_W    = 32,
   parameter int MODE_W    = 5,
   parameter int I_POS     = 7,
   parameter int T_POS     = 5,
   parameter int IRQ_MODE  = 'h12,
   parameter int TRAP_MODE = 'h13,
   parameter int IRQ_VEC   = 'h18,
   parameter int TRAP_VEC  = 'h08,
   parameter int WIDE_OFF  = 4,
   parameter int CMP_OFF   = 0
) (
   input  ent_kind_t         kind,
   input  logic [ST_W-1:0]   stat,
   input  logic [ADDR_W-1:0] pc,
   output logic [ST_W-1:0]   nxt_stat,
   output logic [ADDR_W-1:0] ret_addr,
   output logic [ADDR_W-1:0] vec,
   output logic              mode_diff
);

   localparam logic [MODE_W-1:0] IRQ_M  = MODE_W'(IRQ_MODE);
   localparam logic [MODE_W-1:0] TRAP_M = MODE_W'(TRAP_MODE);
   localparam logic [ADDR_W-1:0] W_OFF  = ADDR_W'(WIDE_OFF);
   localparam logic [ADDR_W-1:0] C_OFF  = ADDR_W'(CMP_OFF);

   logic [MODE_W-1:0] tgt_mode;

   assign tgt_mode = (kind == ENT_TRAP) ? TRAP_M : IRQ_M;
   assign vec      = (kind == ENT_TRAP) ? ADDR_W'(TRAP_VEC) : ADDR_W'(IRQ_VEC);
   assign ret_addr = pc - (stat[T_POS] ? C_OFF : W_OFF);
   assign mode_diff = (stat[MODE_W-1:0] != tgt_mode);

   always_comb begin
      nxt_stat                = stat;
      nxt_stat[I_POS]         = 1'b1;
      nxt_stat[T_POS]         = 1'b0;
      nxt_stat[MODE_W-1:0]    = tgt_mode;
   end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_seq_pkg::*;
#(
   parameter int ST_W       = 32,
   parameter int ADDR_W     = 32,
   parameter int PEND_W     = 14,
   parameter int MODE_W     = 5,
   parameter int I_POS      = 7,
   parameter int T_POS      = 5,
   parameter int RESET_STAT = 'h1F,
   parameter int IRQ_MODE   = 'h12,
   parameter int TRAP_MODE  = 'h13,
   parameter int IRQ_VEC    = 'h18,
   parameter int TRAP_VEC   = 'h08,
   parameter int WIDE_OFF   = 4,
   parameter int CMP_OFF    = 0,
   parameter bit TRAP_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_en,
   input  logic [ST_W-1:0]   stat_in,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [PEND_W-1:0] pend_in,
   input  logic              pf_full,
   input  logic              trap_req,
   output logic [ST_W-1:0]   stat_out,
   output logic [ST_W-1:0]   saved_stat,
   output logic [ADDR_W-1:0] link_out,
   output logic [ADDR_W-1:0] pc_out,
   output logic              reload,
   output logic              halt_rel,
   output logic              bank_sw
);

   localparam logic [ST_W-1:0] RST_ST = ST_W'(RESET_STAT);

   generate
      if (I_POS >= ST_W || T_POS >= ST_W || MODE_W > ST_W) begin : g_bad_pos
         $error("status field position outside status word");
      end
      if (I_POS < MODE_W || T_POS < MODE_W || I_POS == T_POS) begin : g_bad_overlap
         $error("status flag bits overlap the mode field or each other");
      end
      if (PEND_W < 1) begin : g_bad_pend
         $error("pending vector must be at least one bit");
      end
   endgenerate

   ent_kind_t         kind;
   logic [ST_W-1:0]   f_stat;
   logic [ADDR_W-1:0] f_ret;
   logic [ADDR_W-1:0] f_vec;
   logic              f_mdiff;
   logic              take;

   exc_gate #(
      .ST_W(ST_W), .PEND_W(PEND_W), .I_POS(I_POS), .TRAP_EN(TRAP_EN)
   ) u_gate (
      .master_en(master_en), .stat(stat_in), .pend(pend_in),
      .pf_full(pf_full), .trap_req(trap_req), .kind(kind)
   );

   exc_frame #(
      .ST_W(ST_W), .ADDR_W(ADDR_W), .MODE_W(MODE_W), .I_POS(I_POS),
      .T_POS(T_POS), .IRQ_MODE(IRQ_MODE), .TRAP_MODE(TRAP_MODE),
      .IRQ_VEC(IRQ_VEC), .TRAP_VEC(TRAP_VEC), .WIDE_OFF(WIDE_OFF),
      .CMP_OFF(CMP_OFF)
   ) u_frame (
      .kind(kind), .stat(stat_in), .pc(pc_in), .nxt_stat(f_stat),
      .ret_addr(f_ret), .vec(f_vec), .mode_diff(f_mdiff)
   );

   assign take = (kind != ENT_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_out   <= RST_ST;
         saved_stat <= '0;
         link_out   <= '0;
         pc_out     <= '0;
         reload     <= 1'b0;
         halt_rel   <= 1'b0;
         bank_sw    <= 1'b0;
      end else begin
         reload   <= take;
         halt_rel <= (kind == ENT_IRQ);
         bank_sw  <= take & f_mdiff;
         if (take) begin
            stat_out   <= f_stat;
            saved_stat <= stat_in;
            link_out   <= f_ret;
            pc_out     <= f_vec;
         end
      end
   end

   // R4
   full_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload |-> $past(pf_full));

   // R7
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload |-> (stat_out[I_POS] && !stat_out[T_POS]));

   // R9
   halt_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_rel |-> (reload && pc_out == ADDR_W'(IRQ_VEC)));

   // R6
   bank_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reload |-> saved_stat == $past(stat_in));

   // R10
   bank_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_sw |-> reload);

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reload |-> ($stable(pc_out) && $stable(link_out) && !halt_rel));

endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
   localparam int CLK_PERIOD = 10;
   localparam int PW = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        master_en = 1'b0;
   logic [31:0] stat_in = 32'h1F;
   logic [31:0] pc_in = '0;
   logic [PW-1:0] pend_in = '0;
   logic        pf_full = 1'b0;
   logic        trap_req = 1'b0;
   logic [31:0] stat_out, saved_stat, link_out, pc_out;
   logic        reload, halt_rel, bank_sw;

   int n_cmp = 0;
   int n_bad = 0;
   bit started = 1'b0;

   logic [31:0] e_st, e_sav, e_link, e_pc;
   logic        e_rel, e_halt, e_bank;

   exc_entry_seq #(.PEND_W(PW)) dut (
      .clk(clk), .rst_n(rst_n), .master_en(master_en), .stat_in(stat_in),
      .pc_in(pc_in), .pend_in(pend_in), .pf_full(pf_full), .trap_req(trap_req),
      .stat_out(stat_out), .saved_stat(saved_stat), .link_out(link_out),
      .pc_out(pc_out), .reload(reload), .halt_rel(halt_rel), .bank_sw(bank_sw)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference, one update per rising edge
   always @(posedge clk) begin
      bit ti, tt;
      int md;
      started <= 1'b1;
      if (!rst_n) begin
         e_st <= 32'h1F; e_sav <= 0; e_link <= 0; e_pc <= 0;
         e_rel <= 0; e_halt <= 0; e_bank <= 0;
      end else begin
         ti = master_en && (stat_in[7] == 1'b0) && (pend_in != 0) && pf_full;
         tt = trap_req && pf_full && !ti;
         if (ti || tt) begin
            md = ti ? 'h12 : 'h13;
            e_sav  <= stat_in;
            e_link <= stat_in[5] ? pc_in : pc_in - 32'd4;
            e_st   <= {stat_in[31:8], 1'b1, stat_in[6], 1'b0, 5'(md)};
            e_pc   <= ti ? 32'h18 : 32'h08;
            e_rel  <= 1'b1;
            e_halt <= ti;
            e_bank <= (int'(stat_in[4:0]) != md);
         end else begin
            e_rel <= 0; e_halt <= 0; e_bank <= 0;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   // compare every cycle, away from the rising edge
   always @(negedge clk) begin
      if (started) begin
         chk("R2 R3 R4 R8 reload", {31'b0, reload}, {31'b0, e_rel});
         chk("R2 R3 R8 pc_out", pc_out, e_pc);
         chk("R5 link_out", link_out, e_link);
         chk("R6 saved_stat", saved_stat, e_sav);
         chk("R7 R1 stat_out", stat_out, e_st);
         chk("R9 halt_rel", {31'b0, halt_rel}, {31'b0, e_halt});
         chk("R10 bank_sw", {31'b0, bank_sw}, {31'b0, e_bank});
         // R11 is covered by the held values above in idle cycles
      end
   end

   task automatic drive(input bit me, input logic [31:0] st, input logic [31:0] pc,
                        input logic [PW-1:0] pd, input bit full, input bit tr);
      @(negedge clk);
      #1;
      master_en = me; stat_in = st; pc_in = pc; pend_in = pd;
      pf_full = full; trap_req = tr;
   endtask

   initial begin
      #(CLK_PERIOD*100000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] lf;
      lf = 32'hACE1_1234;
      // R1: reset held for a few cycles
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      drive(0, 32'h1F, 32'h100, 0, 0, 0);
      // R2: interrupt in wide state
      drive(1, 32'h1F, 32'h0800_0104, 6'h01, 1, 0);
      drive(0, 32'h1F, 32'h0, 0, 0, 0);
      // R5: interrupt in compact state
      drive(1, 32'hF000_003F, 32'h0800_0202, 6'h20, 1, 0);
      drive(0, 32'h1F, 32'h0, 0, 1, 0);
      // R2: mask bit set, enable off, pending zero
      drive(1, 32'h9F, 32'h300, 6'h3F, 1, 0);
      drive(0, 32'h1F, 32'h300, 6'h3F, 1, 0);
      drive(1, 32'h1F, 32'h300, 6'h00, 1, 0);
      // R4: held request waits for a full buffer
      drive(1, 32'h1F, 32'h400, 6'h04, 0, 0);
      drive(1, 32'h1F, 32'h400, 6'h04, 0, 1);
      drive(1, 32'h1F, 32'h404, 6'h04, 1, 0);
      drive(0, 32'h1F, 32'h0, 0, 0, 0);
      // R3: trap while masked, and both together
      drive(0, 32'h9F, 32'h500, 0, 1, 1);
      drive(1, 32'h10, 32'h600, 6'h02, 1, 1);
      // R10: already in interrupt mode, no bank switch
      drive(1, 32'h12, 32'h700, 6'h08, 1, 0);
      drive(0, 32'h13, 32'h800, 0, 1, 1);
      drive(0, 32'h13, 32'h800, 0, 0, 0);
      // mixed stimulus
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] st;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         st = {lf[31:8] ^ lf[23:0], 8'h0};
         st[7] = lf[3] & lf[9];
         st[5] = lf[4];
         st[4:0] = lf[6] ? (lf[7] ? 5'h12 : 5'h13) : lf[12:8];
         drive(lf[1] | lf[2], st, lf ^ 32'h5A5A_0000, PW'(lf[13:8] & lf[19:14]),
               lf[10] | lf[11], lf[15] & lf[16]);
      end
      drive(0, 32'h1F, 0, 0, 0, 0);
      // R1: reset again mid-run
      @(negedge clk); #1 rst_n = 1'b0;
      repeat (2) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule